// File: doc/BRIEF.md
# Fully Associative Write-Back Byte Cache

This block is a small cache that sits between a processor's request port and a byte-wide main-memory port. It holds eight lines of eight bytes each. Any memory block may occupy any line, and every request compares its tag against all resident tags in the same cycle. Reads and writes that hit are served from the line. Writes stay in the cache and mark the line dirty, so memory is updated only when that line is evicted.

On a miss, the block picks a line to reuse. An empty line is always taken first. If there is none, the block takes the unlocked line that has gone untouched the longest. A dirty line is copied back to memory before the new block is loaded. A request can pin the line it touches so that the line stays resident. If every line is both valid and pinned, the access goes straight to memory as a single byte transfer and nothing is allocated.

Memory traffic is one byte per beat under a valid/ready handshake, with the words of a line sent in ascending order. The processor port holds its request until a one-cycle ready pulse comes back.

Top module: `cache_fa_wb`

## Requirements
- R1: A 16-bit address splits into a word index (bits 2:0) and a tag (bits 15:3). Every line transfer on the memory port uses address {tag, beat}, with beat running from 0 to 7.
- R2: While and after reset, cpu_ready and mem_valid are low, and all lines are invalid, clean and unlocked. The first access to any address after reset refills without a write-back.
- R3: A read hit makes no memory beat. It pulses cpu_ready exactly two clocks after the clock that accepts the request, and cpu_rdata holds the stored byte.
- R4: A write hit updates only the cached byte and makes no memory beat. Its response returns the written byte, and a later read of that address returns it.
- R5: A miss whose chosen line is not dirty makes eight read beats (mem_write=0) at {request tag, 0..7} in ascending order, then answers the request from the new line.
- R6: A miss whose chosen line is dirty first makes eight write beats (mem_write=1) carrying that line's tag and bytes in ascending word order. The refill beats follow.
- R7: After reset, eight distinct blocks are placed in empty lines without evicting one another, and all eight then hit.
- R8: When no line is empty, the victim is the unlocked line with the oldest last touch. Hits, fills and writes all count as touches.
- R9: A request with cpu_lock=1 sets the pin flag of the line it touches. A pinned line is never chosen as a victim.
- R10: When all eight lines are valid and pinned, a miss makes exactly one memory beat at the request address. A read returns mem_rdata and a write sends cpu_wdata. Nothing is allocated.
- R11: A memory beat completes only in a cycle with mem_valid and mem_ready both high. While stalled, mem_addr, mem_write and the write data stay stable.
- R12: cpu_ready is a single-cycle pulse, and it stays low during every write-back or refill beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Request present; held until cpu_ready |
| cpu_write | input | 1 | 1 = write byte, 0 = read byte |
| cpu_lock | input | 1 | Pin the touched line against eviction |
| cpu_addr | input | 16 | Byte address of the request |
| cpu_wdata | input | 8 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Response byte, valid with cpu_ready |
| mem_valid | output | 1 | Memory beat requested |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 16 | Byte address of the beat |
| mem_wdata | output | 8 | Data of a write beat |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 8 | Read data, sampled when the beat completes |

## Verification
The hardest case to reach from the ports is the all-pinned state. Getting there takes a sequence that fills every line, then pins each one with a hit, and arranges along the way that a pinned line is the oldest in recency when a later miss looks for a victim. The stimulus follows a fixed access script whose recency order has been worked out in advance. It first evicts a dirty line. It then makes a pinned line the oldest and checks that the next-oldest line is the one evicted. Finally it pins the rest and checks the single-beat pass-through reads and writes. Part of this runs with memory stalls on alternate cycles.

// File: rtl/cache_fa_pkg.sv
package cache_fa_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB,
      ST_FILL,
      ST_ACC,
      ST_RESP,
      ST_BYP
   } cst_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
   parameter int LINES = 8,
   parameter int TAG_W = 13,
   parameter int IDX_W = 3
) (
   input  logic [TAG_W-1:0] req_tag,
   input  logic [TAG_W-1:0] tags [LINES],
   input  logic [LINES-1:0] valid,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);
   logic [LINES-1:0] eq;

   // one comparator per line, all evaluated together
   for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == req_tag);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int LINES = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [LINES-1:0] valid,
   input  logic [LINES-1:0] lock,
   output logic [IDX_W-1:0] vict_idx,
   output logic             vict_ok
);
   // age rank per line: 0 = newest touch, LINES-1 = oldest
   logic [IDX_W-1:0] rank_q [LINES];
   logic [IDX_W-1:0] touch_rank;
   logic [IDX_W-1:0] best;

   assign touch_rank = rank_q[touch_idx];

   for (genvar g = 0; g < LINES; g++) begin : g_rank
      always_ff @(posedge clk) begin
         if (rst) begin
            rank_q[g] <= IDX_W'(g);
         end else if (touch) begin
            if (touch_idx == IDX_W'(g)) rank_q[g] <= '0;
            else if (rank_q[g] < touch_rank) rank_q[g] <= rank_q[g] + 1'b1;
         end
      end
   end

   always_comb begin
      vict_idx = '0;
      vict_ok  = 1'b0;
      best     = '0;
      // empty lines first, lowest index wins
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            vict_idx = IDX_W'(i);
            vict_ok  = 1'b1;
         end
      end
      // otherwise the oldest unpinned line
      if (!vict_ok) begin
         for (int i = 0; i < LINES; i++) begin
            if (valid[i] && !lock[i] && (!vict_ok || rank_q[i] > best)) begin
               vict_idx = IDX_W'(i);
               best     = rank_q[i];
               vict_ok  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
   parameter int LINES  = 8,
   parameter int WORDS  = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3,
   parameter int WORD_W = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_line,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  a_line,
   input  logic [WORD_W-1:0] a_word,
   output logic [DATA_W-1:0] a_data,
   input  logic [IDX_W-1:0]  b_line,
   input  logic [WORD_W-1:0] b_word,
   output logic [DATA_W-1:0] b_data
);
   logic [DATA_W-1:0] bytes_q [LINES][WORDS];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (wr_en && wr_line == IDX_W'(g)) bytes_q[g][wr_word] <= wr_data;
      end
   end

   assign a_data = bytes_q[a_line][a_word];
   assign b_data = bytes_q[b_line][b_word];
endmodule

// File: rtl/cache_fa_wb.sv
module cache_fa_wb
   import cache_fa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 3,
   parameter int LINES  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic              cpu_lock,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int TAG_W = ADDR_W - WORD_W;
   localparam int WORDS = 1 << WORD_W;
   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

   if (LINES < 2) begin : g_bad_lines
      $error("cache_fa_wb: LINES must be 2 or more");
   end
   if (WORD_W < 1 || ADDR_W <= WORD_W) begin : g_bad_split
      $error("cache_fa_wb: address must hold a word index and a tag");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_pow2
      $error("cache_fa_wb: LINES must be a power of two");
   end

   cst_e              state_q;
   logic              req_write_q, req_lock_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q, rdata_q;
   logic [IDX_W-1:0]  vict_q;
   logic [WORD_W-1:0] beat_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [LINES-1:0]  valid_q, dirty_q, lock_q;

   logic              hit, vict_ok, beat_last, arr_we;
   logic [IDX_W-1:0]  hit_idx, vict_idx;
   logic [WORD_W-1:0] arr_word;
   logic [DATA_W-1:0] arr_wdata, acc_rdata, wb_rdata;
   logic [TAG_W-1:0]  req_tag;
   logic [WORD_W-1:0] req_word;

   assign req_tag   = req_addr_q[ADDR_W-1:WORD_W];
   assign req_word  = req_addr_q[WORD_W-1:0];
   assign beat_last = (beat_q == WORD_W'(WORDS - 1));

   cache_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
      .req_tag (cpu_addr[ADDR_W-1:WORD_W]),
      .tags    (tag_q),
      .valid   (valid_q),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   cache_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
      .clk       (clk),
      .rst       (rst),
      .touch     (state_q == ST_ACC),
      .touch_idx (vict_q),
      .valid     (valid_q),
      .lock      (lock_q),
      .vict_idx  (vict_idx),
      .vict_ok   (vict_ok)
   );

   assign arr_we    = (state_q == ST_FILL && mem_ready) || (state_q == ST_ACC && req_write_q);
   assign arr_word  = (state_q == ST_FILL) ? beat_q : req_word;
   assign arr_wdata = (state_q == ST_FILL) ? mem_rdata : req_wdata_q;

   cache_data_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
                      .IDX_W(IDX_W), .WORD_W(WORD_W)) u_data (
      .clk     (clk),
      .wr_en   (arr_we),
      .wr_line (vict_q),
      .wr_word (arr_word),
      .wr_data (arr_wdata),
      .a_line  (vict_q),
      .a_word  (req_word),
      .a_data  (acc_rdata),
      .b_line  (vict_q),
      .b_word  (beat_q),
      .b_data  (wb_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         req_write_q <= 1'b0;
         req_lock_q  <= 1'b0;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         rdata_q     <= '0;
         vict_q      <= '0;
         beat_q      <= '0;
         valid_q     <= '0;
         dirty_q     <= '0;
         lock_q      <= '0;
         for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_valid) begin
                  req_write_q <= cpu_write;
                  req_lock_q  <= cpu_lock;
                  req_addr_q  <= cpu_addr;
                  req_wdata_q <= cpu_wdata;
                  beat_q      <= '0;
                  if (hit) begin
                     vict_q  <= hit_idx;
                     state_q <= ST_ACC;
                  end else if (vict_ok) begin
                     vict_q  <= vict_idx;
                     state_q <= (valid_q[vict_idx] && dirty_q[vict_idx]) ? ST_WB : ST_FILL;
                  end else begin
                     state_q <= ST_BYP;
                  end
               end
            end
            ST_WB: begin
               if (mem_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_last) begin
                     valid_q[vict_q] <= 1'b0;
                     dirty_q[vict_q] <= 1'b0;
                     state_q         <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (mem_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_last) begin
                     tag_q[vict_q]   <= req_tag;
                     valid_q[vict_q] <= 1'b1;
                     dirty_q[vict_q] <= 1'b0;
                     state_q         <= ST_ACC;
                  end
               end
            end
            ST_ACC: begin
               if (req_write_q) dirty_q[vict_q] <= 1'b1;
               if (req_lock_q) lock_q[vict_q] <= 1'b1;
               rdata_q <= req_write_q ? req_wdata_q : acc_rdata;
               state_q <= ST_RESP;
            end
            ST_BYP: begin
               if (mem_ready) begin
                  rdata_q <= req_write_q ? req_wdata_q : mem_rdata;
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         ST_WB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = {tag_q[vict_q], beat_q};
            mem_wdata = wb_rdata;
         end
         ST_FILL: begin
            mem_valid = 1'b1;
            mem_addr  = {req_tag, beat_q};
         end
         ST_BYP: begin
            mem_valid = 1'b1;
            mem_write = req_write_q;
            mem_addr  = req_addr_q;
            mem_wdata = req_wdata_q;
         end
         default: ;
      endcase
   end

   assign cpu_ready = (state_q == ST_RESP);
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_fa_wb_chk.sv
module cache_fa_wb_chk
   import cache_fa_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input cst_e              state_q,
   input logic [LINES-1:0]  valid_q,
   input logic [LINES-1:0]  dirty_q,
   input logic [LINES-1:0]  lock_q,
   input logic [IDX_W-1:0]  vict_q
);
   assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |=> !cpu_ready);

   assert_quiet_in_refill_R12: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WB || state_q == ST_FILL) |-> !cpu_ready);

   assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                     && (!mem_write || $stable(mem_wdata))));

   assert_pinned_not_victim_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WB || state_q == ST_FILL) |-> !lock_q[vict_q]);

   assert_clean_before_fill_R6: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FILL) |-> !(valid_q[vict_q] && dirty_q[vict_q]));

   assert_valid_from_fill_R2: assert property (@(posedge clk) disable iff (rst)
      ((valid_q & ~$past(valid_q)) != '0) |-> ($past(state_q) == ST_FILL));

   assert_passthru_only_when_full_R10: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BYP) |-> (&(valid_q & lock_q)));
endmodule

bind cache_fa_wb cache_fa_wb_chk #(
   .LINES(LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_cache_fa_wb.sv
module sim_cache_fa_wb;
   localparam int CLK_PERIOD = 10;
   localparam int HIT = 0, FILL = 1, WBFILL = 2, BYP = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_valid, cpu_write, cpu_lock;
   logic [15:0] cpu_addr;
   logic [7:0]  cpu_wdata, cpu_rdata;
   logic        cpu_ready;
   logic        mem_valid, mem_write, mem_ready;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cache_fa_wb u0 (
      .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_lock(cpu_lock),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   typedef struct {
      logic        we;
      logic [15:0] addr;
      logic [7:0]  data;
      int          req;
   } beat_t;

   beat_t      beat_q[$];
   logic [7:0] resp_q[$];
   int         resp_req_q[$];
   logic [7:0] mem_store [logic [15:0]];
   logic [7:0] ref_view  [logic [15:0]];
   int         total = 0, bad = 0, cyc = 0;
   logic       stall_on = 1'b0;
   logic       prev_stall = 1'b0;
   logic [15:0] prev_addr = '0;

   function automatic logic [7:0] seed(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return mem_store.exists(a) ? mem_store[a] : seed(a);
   endfunction

   function automatic logic [7:0] ref_byte(input logic [15:0] a);
      return ref_view.exists(a) ? ref_view[a] : seed(a);
   endfunction

   function automatic logic [12:0] tg(input int k);
      return 13'h0A5 + 13'(k) * 13'h2B1;
   endfunction

   function automatic logic [15:0] ad(input int k, input int w);
      return {tg(k), 3'(w)};
   endfunction

   task automatic check(input bit ok, input int req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: memory model, stall pattern, scoreboard pops
   always @(negedge clk) begin
      beat_t e;
      cyc++;
      mem_ready = stall_on ? cyc[0] : 1'b1;
      if (!rst && prev_stall)  // R11: held beat keeps its address
         check(mem_valid && mem_addr == prev_addr, 11, "stalled beat address", mem_addr, prev_addr);
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      mem_rdata  = mem_byte(mem_addr);
      if (!rst && mem_valid && mem_ready) begin
         if (beat_q.size() == 0) begin
            check(1'b0, 4, "unexpected memory beat", mem_addr, 16'h0);
         end else begin
            e = beat_q.pop_front();
            check(mem_write == e.we, e.req, "beat direction", 16'(mem_write), 16'(e.we));
            check(mem_addr == e.addr, e.req, "beat address", mem_addr, e.addr);
            if (e.we) check(mem_wdata == e.data, e.req, "beat write data", 16'(mem_wdata), 16'(e.data));
         end
         if (mem_write) mem_store[mem_addr] = mem_wdata;
      end
      if (!rst && cpu_ready) begin
         if (resp_q.size() == 0) begin
            check(1'b0, 12, "unexpected response", 16'(cpu_rdata), 16'h0);
         end else begin
            check(cpu_rdata == resp_q[0], resp_req_q[0], "response data", 16'(cpu_rdata), 16'(resp_q[0]));
            void'(resp_q.pop_front());
            void'(resp_req_q.pop_front());
         end
      end
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL R12 watchdog expired actual=%0d expected=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // driver: pushes expected beats and response, then runs the request
   task automatic access(input bit we, input bit lk, input logic [15:0] a, input logic [7:0] wd,
                         input int kind, input logic [12:0] vtag, input int req);
      int n;
      if (kind == WBFILL)   // R6: dirty victim copied out first
         for (int i = 0; i < 8; i++)
            beat_q.push_back('{1'b1, {vtag, 3'(i)}, ref_byte({vtag, 3'(i)}), 6});
      if (kind == FILL || kind == WBFILL)   // R1 R5: ascending refill of {tag, beat}
         for (int i = 0; i < 8; i++)
            beat_q.push_back('{1'b0, {a[15:3], 3'(i)}, 8'h00, 5});
      if (kind == BYP)   // R10: single pass-through beat
         beat_q.push_back('{we, a, wd, 10});
      resp_q.push_back(we ? wd : ref_byte(a));
      resp_req_q.push_back(req);
      if (we) ref_view[a] = wd;
      cpu_valid = 1'b1;
      cpu_write = we;
      cpu_lock  = lk;
      cpu_addr  = a;
      cpu_wdata = wd;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cpu_ready && n < 2000);
      cpu_valid = 1'b0;
      cpu_write = 1'b0;
      cpu_lock  = 1'b0;
      check(n < 2000, req, "request completed", 16'(n), 16'h0);
      if (kind == HIT) check(n == 2, 3, "hit latency", 16'(n), 16'd2);
      check(beat_q.size() == 0, req, "all expected beats seen", 16'(beat_q.size()), 16'h0);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      ref_view = mem_store;
      check(!cpu_ready, 2, "cpu_ready after reset", 16'(cpu_ready), 16'h0);
      check(!mem_valid, 2, "mem_valid after reset", 16'(mem_valid), 16'h0);
   endtask

   initial begin
      cpu_valid = 1'b0;
      cpu_write = 1'b0;
      cpu_lock  = 1'b0;
      cpu_addr  = '0;
      cpu_wdata = '0;
      @(negedge clk);
      do_reset();
      access(0, 0, ad(0, 3), 8'h00, FILL, '0, 5);     // R5 R2
      access(0, 0, ad(0, 5), 8'h00, HIT, '0, 3);      // R3
      access(1, 0, ad(0, 5), 8'hC3, HIT, '0, 4);      // R4
      access(0, 0, ad(0, 5), 8'h00, HIT, '0, 4);      // R4 read back
      stall_on = 1'b1;
      for (int k = 1; k < 8; k++) access(0, 0, ad(k, k), 8'h00, FILL, '0, 7);   // R7 R11
      stall_on = 1'b0;
      for (int k = 1; k < 8; k++) access(0, 0, ad(k, 0), 8'h00, HIT, '0, 7);    // R7 all resident
      // recency oldest->newest: T0(dirty) T1..T7
      access(0, 0, ad(8, 1), 8'h00, WBFILL, tg(0), 6);   // R6
      access(0, 0, ad(1, 0), 8'h00, HIT, '0, 8);         // R8 touch T1
      access(0, 0, ad(9, 2), 8'h00, FILL, '0, 8);        // R8 evicts T2
      access(0, 0, ad(2, 2), 8'h00, FILL, '0, 8);        // R8 T2 gone, evicts T3
      access(0, 0, ad(1, 4), 8'h00, HIT, '0, 8);         // R8 T1 kept
      // order: T4 T5 T6 T7 T8 T9 T2 T1
      access(0, 1, ad(4, 0), 8'h00, HIT, '0, 9);         // R9 pin T4
      for (int k = 5; k < 10; k++) access(0, 0, ad(k, 1), 8'h00, HIT, '0, 9);
      access(0, 0, ad(2, 1), 8'h00, HIT, '0, 9);
      access(0, 0, ad(1, 1), 8'h00, HIT, '0, 9);
      // order: T4(pinned) T5 ... ; T5 must go
      access(0, 0, ad(10, 6), 8'h00, FILL, '0, 9);       // R9
      access(0, 0, ad(4, 0), 8'h00, HIT, '0, 9);         // R9 pinned line kept
      access(1, 1, ad(6, 0), 8'h77, HIT, '0, 9);         // R9 pin dirty
      for (int k = 7; k < 10; k++) access(0, 1, ad(k, 2), 8'h00, HIT, '0, 9);
      access(0, 1, ad(2, 3), 8'h00, HIT, '0, 9);
      access(0, 1, ad(1, 3), 8'h00, HIT, '0, 9);
      access(0, 1, ad(10, 3), 8'h00, HIT, '0, 9);
      stall_on = 1'b1;
      access(0, 0, ad(11, 2), 8'h00, BYP, '0, 10);       // R10 read
      access(1, 0, ad(11, 2), 8'h99, BYP, '0, 10);       // R10 write
      access(0, 0, ad(11, 2), 8'h00, BYP, '0, 10);       // R10 not allocated
      stall_on = 1'b0;
      access(0, 0, ad(6, 0), 8'h00, HIT, '0, 4);         // R4 dirty pinned byte
      do_reset();                                        // R2
      access(0, 0, ad(6, 0), 8'h00, FILL, '0, 2);        // R2 no write-back after reset
      access(0, 0, ad(12, 7), 8'h00, FILL, '0, 1);       // R1
      repeat (4) @(negedge clk);
      check(resp_q.size() == 0, 12, "all responses seen", 16'(resp_q.size()), 16'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule